// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into a real address by walking a hierarchy of translation tables kept in memory. A request carries the virtual address, a 64-bit control word that describes the address space, and an enable for large-frame translation. Depending on the control word, the walk begins at one of three region levels or at the segment level. It descends one table per memory read until it reaches a page entry, ends early on a 1 MB large-frame segment entry, or stops on the first fault. The control word can also select a real space, in which case no walk takes place and the virtual address is returned as the real address.

The walker is a single state machine. Its states are IDLE, CHECK, FETCH, EVAL and DONE. The transitions are:
- IDLE to CHECK when start is sampled; the operands are latched at that point.
- CHECK to DONE for a real space or when the start-level checks fail.
- CHECK to FETCH otherwise.
- FETCH to DONE when the read returns an error.
- FETCH to EVAL when the read returns data.
- EVAL to DONE on a fault or a final result.
- EVAL to FETCH to descend to the next level.
- DONE to IDLE unconditionally.

At most one memory read is outstanding. A request stays asserted with a stable address until it is acknowledged. Write permission starts granted and is narrowed by protection bits along the path.

Top module: `xw_walker`

## Requirements
- R1: When control-word bit 5 (real space) is set, the walk is skipped. The result is the virtual address unchanged, with write permitted and fault code 0.
- R2: Control-word bits 3:2 select the starting level: 3 is region-first, 2 is region-second, 1 is region-third and 0 is segment. The first entry is read at control-word bits 63:12 followed by 12 zero bits, plus 8 times the starting level's index. The index fields of the virtual address are: region-first bits 63:53, region-second bits 52:42, region-third bits 41:31, segment bits 30:20, page bits 19:12 and byte offset bits 11:0.
- R3: If the top 2 bits of the starting level's index exceed control-word bits 1:0, the walk ends with that level's translation fault. No memory read is made. The fault codes are 3 for region-first, 4 for region-second, 5 for region-third, 6 for segment and 7 for page.
- R4: Every index of a level above the starting level must be zero. Otherwise the walk ends with fault code 8 and no memory read.
- R5: A read answered with mem_err ends the walk with fault code 1. Whenever a fault is reported, res_addr is 0 and res_wr is 0.
- R6: An entry with its invalid bit set ends the walk with the translation fault of the level being read. The invalid bit is bit 5 in region and segment entries and bit 10 in page entries.
- R7: Entry bits 3:2 must equal the level code of the table being read: 3 for region-first, 2 for region-second, 1 for region-third and 0 for segment. A mismatch gives fault code 2.
- R8: In a region entry, the top 2 bits of the next level's index must lie in the range from entry bits 7:6 to entry bits 1:0, inclusive. Otherwise the walk ends with the next level's translation fault. The next table's origin is entry bits 63:12 followed by 12 zero bits.
- R9: Region entry bit 9 clears write permission only when large-frame translation is enabled. Segment entry bit 9 and page entry bit 9 always clear it. Once cleared, write permission stays cleared for the rest of the walk.
- R10: A segment entry with bit 4 (common segment) set gives fault code 2 when control-word bit 8 (private space) is set. It has no effect otherwise.
- R11: With large-frame translation enabled and segment entry bit 10 set, the walk ends with the result entry bits 63:20 joined to virtual address bits 19:0. With large-frame translation disabled, bit 10 is ignored. In that case the page entry is read at entry bits 63:11 followed by 11 zero bits, plus 8 times the page index.
- R12: In a page entry, bit 10 set gives fault code 7 and bit 8 set gives fault code 2. Otherwise the result is entry bits 63:12 joined to virtual address bits 11:0.
- R13: done is high for exactly one cycle per accepted start. start is ignored while busy, including the done cycle. mem_req holds with a stable mem_addr until mem_ack. After reset, busy, done and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation; sampled only in IDLE |
| va_in | input | 64 | Virtual address |
| ctl_in | input | 64 | Address-space control word |
| lfe_in | input | 1 | Large-frame translation enable |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 4 | Fault code, 0 when the result is valid |
| res_addr | output | 64 | Real address |
| res_wr | output | 1 | Write permitted |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 64 | Entry byte address, 8-byte aligned |
| mem_ack | input | 1 | Read response valid |
| mem_err | input | 1 | Read failed, qualified by mem_ack |
| mem_rdata | input | 64 | Entry data, qualified by mem_ack |

## Verification
Two events can fall in the same cycle: a fresh start request and the completion pulse of the walk in progress. The same overlap arises when a start is raised while the walker is still mid-walk. The bench provokes this by holding start high, with operands different from the accepted ones, from the cycle after acceptance through the done cycle, with memory responses randomly stalled. It judges the outcome by three things: the result must match the first operands, done must drop after one cycle, and no further done or busy may follow.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int ADDR_W    = 64;
    localparam int IDX_W     = 11;
    localparam int PIDX_W    = 8;
    localparam int OFF_W     = 12;
    localparam int FAULT_W   = 4;
    localparam int N_TBL     = 4;
    localparam int ENTRY_SH  = 3;
    localparam int SEG_LSB   = OFF_W + PIDX_W;
    localparam int PT_ALIGN  = PIDX_W + ENTRY_SH;
    localparam int RT_ALIGN  = OFF_W;

    localparam int CW_REAL   = 5;
    localparam int CW_PRIV   = 8;
    localparam int TYPE_LSB  = 2;
    localparam int TF_LSB    = 6;
    localparam int E_INV     = 5;
    localparam int E_CS      = 4;
    localparam int E_PROT    = 9;
    localparam int E_FC      = 10;
    localparam int P_INV     = 10;
    localparam int P_MBZ     = 8;

    typedef enum logic [2:0] {
        LV_PAGE = 3'd0,
        LV_SEG  = 3'd1,
        LV_R3   = 3'd2,
        LV_R2   = 3'd3,
        LV_R1   = 3'd4
    } level_e;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE  = 4'd0,
        FLT_ADDR  = 4'd1,
        FLT_SPEC  = 4'd2,
        FLT_R1    = 4'd3,
        FLT_R2    = 4'd4,
        FLT_R3    = 4'd5,
        FLT_SEG   = 4'd6,
        FLT_PAGE  = 4'd7,
        FLT_SPACE = 4'd8
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_EVAL,
        S_DONE
    } state_e;

    function automatic fault_e level_fault(input level_e lv);
        fault_e f;
        unique case (lv)
            LV_R1:   f = FLT_R1;
            LV_R2:   f = FLT_R2;
            LV_R3:   f = FLT_R3;
            LV_SEG:  f = FLT_SEG;
            default: f = FLT_PAGE;
        endcase
        return f;
    endfunction

    function automatic logic [ADDR_W-1:0] idx_off(input logic [IDX_W-1:0] i);
        return {{(ADDR_W-IDX_W-ENTRY_SH){1'b0}}, i, {ENTRY_SH{1'b0}}};
    endfunction
endpackage

// File: rtl/xw_index_sel.sv
module xw_index_sel
    import xw_pkg::*;
(
    input  logic [ADDR_W-1:0]             va,
    output logic [N_TBL-1:0][IDX_W-1:0]   tbl_idx,
    output logic [PIDX_W-1:0]             pg_idx,
    output logic [SEG_LSB-1:0]            va_low
);
    // tbl_idx[0] = segment, [1] = region-third, [2] = region-second, [3] = region-first
    for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
        assign tbl_idx[g] = va[SEG_LSB + g*IDX_W +: IDX_W];
    end

    assign pg_idx = va[OFF_W +: PIDX_W];
    assign va_low = va[SEG_LSB-1:0];
endmodule

// File: rtl/xw_start_check.sv
module xw_start_check
    import xw_pkg::*;
(
    input  logic [ADDR_W-RT_ALIGN-1:0]    origin,
    input  logic [1:0]                    ttype,
    input  logic [1:0]                    tlen,
    input  logic [N_TBL-1:0][IDX_W-1:0]   tbl_idx,
    output fault_e                        start_fault,
    output level_e                        start_lv,
    output logic [ADDR_W-1:0]             first_addr
);
    logic        upper_nz;
    logic [1:0]  top_bits;
    int unsigned sel_i;

    always_comb begin
        sel_i    = 32'(ttype);
        start_lv = level_e'({1'b0, ttype} + 3'd1);
        upper_nz = 1'b0;
        for (int unsigned g = 0; g < N_TBL; g++) begin
            if (g > sel_i && tbl_idx[g] != '0) begin
                upper_nz = 1'b1;
            end
        end
        top_bits   = tbl_idx[ttype][IDX_W-1 -: 2];
        first_addr = {origin, {RT_ALIGN{1'b0}}} + idx_off(tbl_idx[ttype]);
        if (upper_nz) begin
            start_fault = FLT_SPACE;
        end else if (top_bits > tlen) begin
            start_fault = level_fault(start_lv);
        end else begin
            start_fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval
    import xw_pkg::*;
(
    input  logic [ADDR_W-1:0]             entry,
    input  level_e                        lv,
    input  logic [N_TBL-1:0][IDX_W-1:0]   tbl_idx,
    input  logic [PIDX_W-1:0]             pg_idx,
    input  logic [SEG_LSB-1:0]            va_low,
    input  logic                          lfe,
    input  logic                          priv,
    output fault_e                        fault,
    output logic                          prot,
    output logic                          leaf,
    output logic [ADDR_W-1:0]             out_addr
);
    logic [1:0] cur_g;
    logic [1:0] nxt_g;
    logic [1:0] nxt_top;
    logic [1:0] tf;
    logic [1:0] tl;
    logic [1:0] etype;

    always_comb begin
        cur_g    = 2'(lv - 3'd1);
        nxt_g    = 2'(lv - 3'd2);
        nxt_top  = tbl_idx[nxt_g][IDX_W-1 -: 2];
        tf       = entry[TF_LSB +: 2];
        tl       = entry[1:0];
        etype    = entry[TYPE_LSB +: 2];
        fault    = FLT_NONE;
        prot     = 1'b0;
        leaf     = 1'b0;
        out_addr = '0;
        unique case (lv)
            LV_PAGE: begin
                if (entry[P_INV]) begin
                    fault = FLT_PAGE;
                end else if (entry[P_MBZ]) begin
                    fault = FLT_SPEC;
                end else begin
                    prot     = entry[E_PROT];
                    leaf     = 1'b1;
                    out_addr = {entry[ADDR_W-1:OFF_W], va_low[OFF_W-1:0]};
                end
            end
            LV_SEG: begin
                if (entry[E_INV]) begin
                    fault = FLT_SEG;
                end else if (etype != 2'd0) begin
                    fault = FLT_SPEC;
                end else if (entry[E_CS] && priv) begin
                    fault = FLT_SPEC;
                end else begin
                    prot = entry[E_PROT];
                    if (lfe && entry[E_FC]) begin
                        leaf     = 1'b1;
                        out_addr = {entry[ADDR_W-1:SEG_LSB], va_low};
                    end else begin
                        out_addr = {entry[ADDR_W-1:PT_ALIGN], {PT_ALIGN{1'b0}}}
                                 + idx_off({{(IDX_W-PIDX_W){1'b0}}, pg_idx});
                    end
                end
            end
            LV_R3, LV_R2, LV_R1: begin
                if (entry[E_INV]) begin
                    fault = level_fault(lv);
                end else if (etype != cur_g) begin
                    fault = FLT_SPEC;
                end else if (nxt_top < tf || nxt_top > tl) begin
                    fault = level_fault(level_e'(lv - 3'd1));
                end else begin
                    prot     = lfe & entry[E_PROT];
                    out_addr = {entry[ADDR_W-1:RT_ALIGN], {RT_ALIGN{1'b0}}}
                             + idx_off(tbl_idx[nxt_g]);
                end
            end
            default: fault = FLT_SPEC;
        endcase
    end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [63:0]        va_in,
    input  logic [63:0]        ctl_in,
    input  logic               lfe_in,
    output logic               busy,
    output logic               done,
    output logic [3:0]         fault,
    output logic [63:0]        res_addr,
    output logic               res_wr,
    output logic               mem_req,
    output logic [63:0]        mem_addr,
    input  logic               mem_ack,
    input  logic               mem_err,
    input  logic [63:0]        mem_rdata
);
    state_e                      state_q, state_d;
    logic [ADDR_W-1:0]           va_q, ctl_q, addr_q, entry_q, res_q;
    logic                        lfe_q, wr_q;
    level_e                      lv_q;
    fault_e                      fault_q;

    logic [N_TBL-1:0][IDX_W-1:0] tbl_idx;
    logic [PIDX_W-1:0]           pg_idx;
    logic [SEG_LSB-1:0]          va_low;
    fault_e                      start_fault;
    level_e                      start_lv;
    logic [ADDR_W-1:0]           first_addr;
    fault_e                      ev_fault;
    logic                        ev_prot, ev_leaf;
    logic [ADDR_W-1:0]           ev_addr;
    logic                        unused_ctl_bits;

    assign unused_ctl_bits = ^{ctl_q[11:9], ctl_q[7:6], ctl_q[4]};

    xw_index_sel u_idx (
        .va      (va_q),
        .tbl_idx (tbl_idx),
        .pg_idx  (pg_idx),
        .va_low  (va_low)
    );

    xw_start_check u_start (
        .origin      (ctl_q[ADDR_W-1:RT_ALIGN]),
        .ttype       (ctl_q[TYPE_LSB +: 2]),
        .tlen        (ctl_q[1:0]),
        .tbl_idx     (tbl_idx),
        .start_fault (start_fault),
        .start_lv    (start_lv),
        .first_addr  (first_addr)
    );

    xw_entry_eval u_eval (
        .entry    (entry_q),
        .lv       (lv_q),
        .tbl_idx  (tbl_idx),
        .pg_idx   (pg_idx),
        .va_low   (va_low),
        .lfe      (lfe_q),
        .priv     (ctl_q[CW_PRIV]),
        .fault    (ev_fault),
        .prot     (ev_prot),
        .leaf     (ev_leaf),
        .out_addr (ev_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_CHECK;
            S_CHECK: begin
                if (ctl_q[CW_REAL] || start_fault != FLT_NONE) begin
                    state_d = S_DONE;
                end else begin
                    state_d = S_FETCH;
                end
            end
            S_FETCH: if (mem_ack) state_d = mem_err ? S_DONE : S_EVAL;
            S_EVAL: begin
                if (ev_fault != FLT_NONE || ev_leaf) begin
                    state_d = S_DONE;
                end else begin
                    state_d = S_FETCH;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            ctl_q   <= '0;
            lfe_q   <= 1'b0;
            addr_q  <= '0;
            entry_q <= '0;
            res_q   <= '0;
            wr_q    <= 1'b0;
            lv_q    <= LV_PAGE;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        va_q    <= va_in;
                        ctl_q   <= ctl_in;
                        lfe_q   <= lfe_in;
                        wr_q    <= 1'b1;
                        res_q   <= '0;
                        fault_q <= FLT_NONE;
                    end
                end
                S_CHECK: begin
                    if (ctl_q[CW_REAL]) begin
                        res_q <= va_q;
                    end else if (start_fault != FLT_NONE) begin
                        fault_q <= start_fault;
                    end else begin
                        addr_q <= first_addr;
                        lv_q   <= start_lv;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            fault_q <= FLT_ADDR;
                        end else begin
                            entry_q <= mem_rdata;
                        end
                    end
                end
                S_EVAL: begin
                    if (ev_fault != FLT_NONE) begin
                        fault_q <= ev_fault;
                    end else begin
                        if (ev_prot) wr_q <= 1'b0;
                        if (ev_leaf) begin
                            res_q <= ev_addr;
                        end else begin
                            addr_q <= ev_addr;
                            lv_q   <= level_e'(lv_q - 3'd1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        done     = (state_q == S_DONE);
        mem_req  = (state_q == S_FETCH);
        mem_addr = addr_q;
        fault    = fault_q;
        res_addr = (fault_q == FLT_NONE) ? res_q : '0;
        res_wr   = (fault_q == FLT_NONE) && wr_q;
    end
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [3:0]  fault,
    input logic [63:0] res_addr,
    input logic        res_wr,
    input logic        mem_req,
    input logic [63:0] mem_addr,
    input logic        mem_ack,
    input logic        mem_err
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R13

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done)); // R13

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000)); // R2

    AST_ERR_ADDR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (done && fault == 4'd1)); // R5

    AST_FAULT_CLEARS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 4'd0) |-> (!res_wr && res_addr == 64'd0)); // R5
endmodule

bind xw_walker xw_walker_chk chk_i (.*);

// File: tb/xw_walker_tb_top.sv
module xw_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] va_in = '0, ctl_in = '0;
    logic        lfe_in = 1'b0;
    logic        busy, done, res_wr, mem_req;
    logic [3:0]  fault;
    logic [63:0] res_addr, mem_addr;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] mem [0:MEM_WORDS-1];
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .va_in(va_in), .ctl_in(ctl_in),
        .lfe_in(lfe_in), .busy(busy), .done(done), .fault(fault),
        .res_addr(res_addr), .res_wr(res_wr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata)
    );

    // behavioural memory, 32 KB, random stalls, error beyond its range
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack && ($urandom % 3 != 0)) begin
            mem_ack   <= 1'b1;
            mem_err   <= (mem_addr[63:15] != 0);
            mem_rdata <= mem[mem_addr[14:3]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit rd(input logic [63:0] a, output logic [63:0] e);
        if (a[63:15] != 0) return 1'b0;
        e = mem[a[14:3]];
        return 1'b1;
    endfunction

    // reference translation computed from the requirements
    function automatic void ref_walk(input logic [63:0] va, input logic [63:0] ctl,
                                     input bit lfe, output int flt,
                                     output logic [63:0] ra, output bit wr);
        int idx [4];
        int t, nt;
        logic [63:0] a, e;
        wr = 1; ra = 0; flt = 0;
        if (ctl[5]) begin ra = va; return; end
        idx[0] = int'(va[30:20]); idx[1] = int'(va[41:31]);
        idx[2] = int'(va[52:42]); idx[3] = int'(va[63:53]);
        t = int'(ctl[3:2]);
        for (int g = t + 1; g < 4; g++)
            if (idx[g] != 0) begin flt = 8; wr = 0; return; end
        if ((idx[t] >> 9) > int'(ctl[1:0])) begin flt = 6 - t; wr = 0; return; end
        a = {ctl[63:12], 12'b0} + 64'(idx[t]) * 8;
        for (int g = t; g >= 0; g--) begin
            if (!rd(a, e)) begin flt = 1; wr = 0; return; end
            if (e[5]) begin flt = 6 - g; wr = 0; return; end
            if (int'(e[3:2]) != g) begin flt = 2; wr = 0; return; end
            if (g > 0) begin
                nt = idx[g-1] >> 9;
                if (nt < int'(e[7:6]) || nt > int'(e[1:0])) begin
                    flt = 7 - g; wr = 0; return;
                end
                if (lfe && e[9]) wr = 0;
                a = {e[63:12], 12'b0} + 64'(idx[g-1]) * 8;
            end else begin
                if (e[4] && ctl[8]) begin flt = 2; wr = 0; return; end
                if (e[9]) wr = 0;
                if (lfe && e[10]) begin ra = {e[63:20], va[19:0]}; return; end
                a = {e[63:11], 11'b0} + 64'(va[19:12]) * 8;
            end
        end
        if (!rd(a, e)) begin flt = 1; wr = 0; return; end
        if (e[10]) begin flt = 7; wr = 0; return; end
        if (e[8])  begin flt = 2; wr = 0; return; end
        if (e[9]) wr = 0;
        ra = {e[63:12], va[11:0]};
    endfunction

    function automatic string tag_of(input logic [63:0] ctl, input int f);
        if (ctl[5]) return "R1";
        case (f)
            0: return "R12";
            1: return "R5";
            2: return "R7";
            8: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic walk(input logic [63:0] va, input logic [63:0] ctl, input bit lfe,
                        input bit poke, output logic [3:0] f,
                        output logic [63:0] ra, output bit wr);
        int wait_n = 0;
        @(negedge clk);
        start = 1; va_in = va; ctl_in = ctl; lfe_in = lfe;
        @(negedge clk);
        start = poke; va_in = {$urandom, $urandom}; ctl_in = {$urandom, $urandom};
        lfe_in = ~lfe;
        while (!done && wait_n < 500) begin
            @(negedge clk);
            wait_n++;
        end
        check(done, "R13", "walk completes", 64'(done), 64'd1);
        f = fault; ra = res_addr; wr = res_wr;
        @(negedge clk);
        start = 0;
        check(!done, "R13", "done lasts one cycle", 64'(done), 64'd0);
        if (poke) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check(!done && !busy, "R13", "start while busy ignored",
                      {62'd0, done, busy}, 64'd0);
            end
        end
    endtask

    task automatic run_ref(input logic [63:0] va, input logic [63:0] ctl,
                           input bit lfe, input bit poke);
        logic [3:0] f; logic [63:0] ra; bit wr;
        int ef; logic [63:0] era; bit ewr;
        string tg;
        ref_walk(va, ctl, lfe, ef, era, ewr);
        tg = tag_of(ctl, ef);
        walk(va, ctl, lfe, poke, f, ra, wr);
        check(int'(f) == ef, tg, "fault code", 64'(f), 64'(ef));
        check(ra == era, tg, "real address", ra, era);
        check(wr == ewr, "R9", "write flag", 64'(wr), 64'(ewr));
    endtask

    task automatic run_dir(input logic [63:0] va, input logic [63:0] ctl, input bit lfe,
                           input int ef, input logic [63:0] era, input bit ewr,
                           input string tg);
        logic [3:0] f; logic [63:0] ra; bit wr;
        walk(va, ctl, lfe, 1'b0, f, ra, wr);
        check(int'(f) == ef, tg, "fault code", 64'(f), 64'(ef));
        check(ra == era, tg, "real address", ra, era);
        check(wr == ewr, tg, "write flag", 64'(wr), 64'(ewr));
    endtask

    function automatic logic [63:0] rgn(input int slot, input int g, input int tf,
                                        input int tl, input bit p, input bit inv);
        logic [63:0] e = '0;
        e[63:12] = 52'(slot); e[9] = p; e[7:6] = 2'(tf); e[5] = inv;
        e[3:2] = 2'(g); e[1:0] = 2'(tl);
        return e;
    endfunction

    function automatic logic [63:0] sgm(input int slot2k, input bit fc, input bit p,
                                        input bit cs, input bit inv);
        logic [63:0] e = '0;
        e[63:11] = 53'(slot2k); e[10] = fc; e[9] = p; e[5] = inv; e[4] = cs;
        return e;
    endfunction

    function automatic logic [63:0] pge(input logic [51:0] frame, input bit p,
                                        input bit inv, input bit mbz);
        logic [63:0] e = '0;
        e[63:12] = frame; e[10] = inv; e[9] = p; e[8] = mbz;
        return e;
    endfunction

    // directed chain: R1 table 0x1000, R2 0x2000, R3 0x3000, segment 0x4000, page 0x5000
    task automatic chain(input bit rp, input bit fc, input bit sp, input bit pp);
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        mem[12'h200] = rgn(2, 3, 0, 3, rp, 0);
        mem[12'h400] = rgn(3, 2, 0, 3, 0, 0);
        mem[12'h600] = rgn(4, 1, 0, 3, 0, 0);
        mem[12'h800] = sgm(10, fc, sp, 0, 0);
        mem[12'hA05] = pge(52'hABCDE, pp, 0, 0);
    endtask

    // random chain along the path of a random request
    task automatic build(output logic [63:0] va, output logic [63:0] ctl, output bit lfe);
        int idx [4];
        int t, slot;
        logic [63:0] a, e;
        t = int'($urandom % 4);
        for (int g = 0; g < 4; g++) begin
            if (g > t) idx[g] = ($urandom % 16 == 0) ? int'($urandom % 8) : 0;
            else idx[g] = ($urandom % 8 == 0) ? int'($urandom % 2048) : int'($urandom % 64);
        end
        va = {11'(idx[3]), 11'(idx[2]), 11'(idx[1]), 11'(idx[0]), 20'($urandom)};
        lfe = 1'($urandom);
        ctl = '0;
        ctl[63:12] = ($urandom % 32 == 0) ? 52'h100 : 52'($urandom % 7);
        ctl[8] = 1'($urandom);
        ctl[5] = ($urandom % 16 == 0);
        ctl[3:2] = 2'(t);
        ctl[1:0] = ($urandom % 4 == 0) ? 2'($urandom) : 2'd3;
        a = {ctl[63:12], 12'b0} + 64'(idx[t]) * 8;
        for (int g = t; g >= 0; g--) begin
            if (a[63:15] != 0) return;
            slot = int'($urandom % 7);
            if (g > 0) begin
                e = rgn(slot, g, 0, 3, ($urandom % 4 == 0), ($urandom % 16 == 0));
                if ($urandom % 16 == 0) e[3:2] = 2'($urandom);
                if ($urandom % 8 == 0) begin e[7:6] = 2'($urandom); e[1:0] = 2'($urandom); end
                mem[a[14:3]] = e;
                a = {e[63:12], 12'b0} + 64'(idx[g-1]) * 8;
            end else begin
                e = sgm(int'($urandom % 14), ($urandom % 3 == 0), ($urandom % 4 == 0),
                        ($urandom % 8 == 0), ($urandom % 16 == 0));
                if ($urandom % 16 == 0) e[3:2] = 2'($urandom);
                mem[a[14:3]] = e;
                a = {e[63:11], 11'b0} + 64'(va[19:12]) * 8;
            end
        end
        if (a[63:15] == 0)
            mem[a[14:3]] = pge(52'({$urandom, $urandom}), ($urandom % 4 == 0),
                               ($urandom % 16 == 0), ($urandom % 16 == 0));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] va, ctl;
        bit lfe;
        void'($urandom(32'd1234));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R13", "reset state",
              {61'd0, busy, done, mem_req}, 64'd0);
        rst_n = 1'b1;

        // R1 real space
        run_dir(64'hDEAD_BEEF_0123_4567, 64'h20, 1'b0, 0, 64'hDEAD_BEEF_0123_4567, 1, "R1");
        // R2 each start level reaches the same page
        chain(0, 0, 0, 0);
        run_dir(64'h5123, 64'h100F, 1'b0, 0, 64'hABCDE123, 1, "R2");
        run_dir(64'h5123, 64'h2003 | 64'h8, 1'b0, 0, 64'hABCDE123, 1, "R2");
        run_dir(64'h5123, 64'h3007, 1'b0, 0, 64'hABCDE123, 1, "R2");
        run_dir(64'h5123, 64'h4003, 1'b0, 0, 64'hABCDE123, 1, "R2");
        // R9 region protection depends on large-frame enable; segment/page always
        chain(1, 0, 0, 0);
        run_dir(64'h5123, 64'h100F, 1'b0, 0, 64'hABCDE123, 1, "R9");
        run_dir(64'h5123, 64'h100F, 1'b1, 0, 64'hABCDE123, 0, "R9");
        chain(0, 0, 1, 0);
        run_dir(64'h5123, 64'h100F, 1'b0, 0, 64'hABCDE123, 0, "R9");
        chain(0, 0, 0, 1);
        run_dir(64'h5123, 64'h100F, 1'b0, 0, 64'hABCDE123, 0, "R9");
        // R11 large frame only when enabled
        chain(0, 1, 0, 0);
        run_dir(64'h5123, 64'h100F, 1'b1, 0, 64'h5123, 1, "R11");
        run_dir(64'h5123, 64'h100F, 1'b0, 0, 64'hABCDE123, 1, "R11");
        // R3 table length at start level
        chain(0, 0, 0, 0);
        run_dir(64'h2000_5123, 64'h4000, 1'b0, 6, 64'd0, 0, "R3");
        // R4 nonzero skipped index
        run_dir(64'h5123 | (64'd1 << 53), 64'h4003, 1'b0, 8, 64'd0, 0, "R4");
        // R5 read error
        run_dir(64'h5123, 64'h0010_0000_0000_000F, 1'b0, 1, 64'd0, 0, "R5");
        // R8 range check at region-first and region-third
        mem[12'h200] = rgn(2, 3, 0, 0, 0, 0);
        run_dir(64'h5123 | (64'h200 << 42), 64'h100F, 1'b0, 4, 64'd0, 0, "R8");
        chain(0, 0, 0, 0);
        mem[12'h600] = rgn(4, 1, 2, 3, 0, 0);
        run_dir(64'h5123, 64'h3007, 1'b0, 6, 64'd0, 0, "R8");
        // R6 invalid entries
        chain(0, 0, 0, 0);
        mem[12'h400] = rgn(3, 2, 0, 3, 0, 1);
        run_dir(64'h5123, 64'h100F, 1'b0, 4, 64'd0, 0, "R6");
        chain(0, 0, 0, 0);
        mem[12'h800] = sgm(10, 0, 0, 0, 1);
        run_dir(64'h5123, 64'h100F, 1'b0, 6, 64'd0, 0, "R6");
        // R7 type mismatch
        chain(0, 0, 0, 0);
        mem[12'h600] = rgn(4, 2, 0, 3, 0, 0);
        run_dir(64'h5123, 64'h100F, 1'b0, 2, 64'd0, 0, "R7");
        // R10 common segment
        chain(0, 0, 0, 0);
        mem[12'h800] = sgm(10, 0, 0, 1, 0);
        run_dir(64'h5123, 64'h110F, 1'b0, 2, 64'd0, 0, "R10");
        run_dir(64'h5123, 64'h100F, 1'b0, 0, 64'hABCDE123, 1, "R10");
        // R12 page faults
        chain(0, 0, 0, 0);
        mem[12'hA05] = pge(52'hABCDE, 0, 1, 0);
        run_dir(64'h5123, 64'h100F, 1'b0, 7, 64'd0, 0, "R12");
        mem[12'hA05] = pge(52'hABCDE, 0, 0, 1);
        run_dir(64'h5123, 64'h100F, 1'b0, 2, 64'd0, 0, "R12");

        // R13 start held through the walk and the done cycle
        chain(0, 0, 0, 0);
        run_ref(64'h5123, 64'h100F, 1'b0, 1'b1);
        run_ref(64'h7777, 64'h20, 1'b1, 1'b1);

        // constrained random walks
        for (int n = 0; n < 400; n++) begin
            build(va, ctl, lfe);
            run_ref(va, ctl, lfe, (n % 10 == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule